// File: doc/BRIEF.md
# Byte-Sequence Unlock Detector

This block guards entry into a privileged programming mode. It watches an 8-bit data port together with a strobe input that is asynchronous to the system clock. Each strobe pulse presents one byte. Only a fixed eight-byte code, presented in order, moves the block out of normal mode. The block raises its mode flag when the strobe falls at the end of the last correct byte. From then on the mode is held until the next reset. A progress output reports how many bytes of the code have matched so far.

Both the strobe and the data pass through synchronizer stages of equal depth, so they stay aligned in the clock domain. A byte is captured on the synchronized rising edge of the strobe. It is judged on the falling edge, and only if the data did not move while the strobe was high. A wrong byte restarts the match. If that wrong byte is itself the first code byte, it counts as the start of a new attempt.

A command request input is passed through to a grant output only while programming mode is active. Before unlock, commands are ignored.

The reset input asserts asynchronously and is released synchronously inside the block. Unlocking can begin only after that internal release.

Top module: `ulk_unlock_detector`

## Requirements
- R1: While reset is asserted and directly after it, `prog_mode_o` is 0, `match_cnt_o` is 0 and `cmd_grant_o` is 0.
- R2: The code is the byte order A5h, 5Ah, A5h, F0h, 0Fh, 00h, F1h, 00h. `prog_mode_o` rises only after the strobe falls at the end of the eighth correct byte. While that eighth pulse is still high, the mode stays 0 and the count stays 7.
- R3: After each completed strobe pulse of a correct byte in order, `match_cnt_o` equals the number of code bytes matched so far, from 1 up to 8.
- R4: A completed pulse whose byte differs from the expected code byte sets `match_cnt_o` to 1 if the byte is A5h, and to 0 otherwise. `prog_mode_o` stays 0.
- R5: If the data changes while the strobe is high, that pulse counts as a mismatch and `match_cnt_o` becomes 0, whatever value was captured.
- R6: Once `prog_mode_o` is 1, it stays 1 and `match_cnt_o` stays 8 through any further strobe pulses and data, until reset.
- R7: A reset applied in programming mode returns `prog_mode_o` and `match_cnt_o` to 0.
- R8: `cmd_grant_o` equals `cmd_req_i` while `prog_mode_o` is 1, and is 0 otherwise.
- R9: A strobe that is already high when reset is released is discarded. Its falling edge changes nothing, and the next full pulse is judged normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release inside |
| strobe_i | input | 1 | Byte strobe, asynchronous; one byte per high pulse |
| data_i | input | 8 | Byte presented during a strobe pulse |
| cmd_req_i | input | 1 | Request for a programming command |
| prog_mode_o | output | 1 | 1 when programming mode is active |
| match_cnt_o | output | 4 | Number of code bytes matched so far (0 to 8) |
| cmd_grant_o | output | 1 | Command request passed through in programming mode |

## Verification
The bench builds the block with its default parameters: an 8-bit port, the eight-byte code and two synchronizer stages. With these values a full sweep is affordable. For every code position from 0 to 7, the bench enters the correct prefix and then tries all 256 byte values at that position. Each result is checked against a count worked out arithmetically. This covers every mismatch and restart case, including A5h arriving where another byte was expected. Directed sequences then cover the moment of unlock within the last pulse, unstable data during a pulse, a strobe held high across reset release, stickiness after unlock and command gating.

// File: rtl/ulk_pkg.sv
package ulk_pkg;
  // Code byte k sits at bits [8k+7:8k]; byte 0 is presented first.
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_CODE_N = 8;
  localparam logic [DEF_CODE_N*DEF_BYTE_W-1:0] DEF_CODE = 64'h00F1_000F_F0A5_5AA5;
endpackage

// File: rtl/ulk_rst_sync.sv
module ulk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ulk_strobe_sampler.sv
module ulk_strobe_sampler #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_val_o,
  output logic              byte_clean_o
);
  logic [SYNC_STAGES-1:0]             strb_sync_q, strb_sync_d;
  logic [SYNC_STAGES-1:0][BYTE_W-1:0] data_pipe_q, data_pipe_d;
  logic                               strb_last_q;
  logic [BYTE_W-1:0]                  cap_q, cap_d;
  logic                               armed_q, armed_d;
  logic                               dirty_q, dirty_d;
  logic                               strb_s;
  logic [BYTE_W-1:0]                  data_s;
  logic                               rise, fall;

  assign strb_s = strb_sync_q[SYNC_STAGES-1];
  assign data_s = data_pipe_q[SYNC_STAGES-1];
  assign rise   = strb_s & ~strb_last_q;
  assign fall   = ~strb_s & strb_last_q;

  always_comb begin
    strb_sync_d = {strb_sync_q[SYNC_STAGES-2:0], strobe_i};
    data_pipe_d = {data_pipe_q[SYNC_STAGES-2:0], data_i};
    cap_d       = cap_q;
    armed_d     = armed_q;
    dirty_d     = dirty_q;
    if (rise) begin
      cap_d   = data_s;
      armed_d = 1'b1;
      dirty_d = 1'b0;
    end else if (fall) begin
      armed_d = 1'b0;
    end else if (strb_s && armed_q && (data_s != cap_q)) begin
      dirty_d = 1'b1;
    end
  end

  // The chain resets to "high" so a pulse in progress at release is never armed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_sync_q <= '1;
      data_pipe_q <= '0;
      strb_last_q <= 1'b1;
      cap_q       <= '0;
      armed_q     <= 1'b0;
      dirty_q     <= 1'b0;
    end else begin
      strb_sync_q <= strb_sync_d;
      data_pipe_q <= data_pipe_d;
      strb_last_q <= strb_s;
      cap_q       <= cap_d;
      armed_q     <= armed_d;
      dirty_q     <= dirty_d;
    end
  end

  assign byte_done_o  = fall & armed_q;
  assign byte_val_o   = cap_q;
  assign byte_clean_o = ~dirty_q;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall})); // R2
  AST_DONE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> $past(armed_d)); // R9
endmodule

// File: rtl/ulk_seq_matcher.sv
module ulk_seq_matcher #(
  parameter int unsigned                   BYTE_W = 8,
  parameter int unsigned                   CODE_N = 8,
  parameter logic [CODE_N*BYTE_W-1:0]      CODE   = ulk_pkg::DEF_CODE,
  localparam int unsigned                  CW     = $clog2(CODE_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_val_i,
  input  logic              byte_clean_i,
  output logic [CW-1:0]     idx_o,
  output logic              unlocked_o
);
  localparam logic [CW-1:0] LAST_IDX = CW'(CODE_N - 1);

  logic [CW-1:0]     idx_q, idx_d;
  logic              unl_q, unl_d;
  logic [BYTE_W-1:0] exp_byte;
  logic [BYTE_W-1:0] first_byte;

  assign first_byte = CODE[BYTE_W-1:0];

  always_comb begin
    exp_byte = first_byte;
    for (int i = 0; i < CODE_N; i++) begin
      if (idx_q == CW'(i)) exp_byte = CODE[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    idx_d = idx_q;
    unl_d = unl_q;
    if (!unl_q && byte_done_i) begin
      if (byte_clean_i && (byte_val_i == exp_byte)) begin
        idx_d = idx_q + CW'(1);
        if (idx_q == LAST_IDX) unl_d = 1'b1;
      end else if (byte_clean_i && (byte_val_i == first_byte)) begin
        idx_d = CW'(1);
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      unl_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      unl_q <= unl_d;
    end
  end

  assign idx_o      = idx_q;
  assign unlocked_o = unl_q;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unl_q |=> unl_q); // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= CW'(CODE_N)); // R3
  AST_MODE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    unl_q |-> (idx_q == CW'(CODE_N))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done_i |=> $stable(idx_q)); // R3
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unl_q |=> $stable(idx_q)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> ((idx_q == $past(idx_q) + CW'(1)) || (idx_q <= CW'(1)))); // R4
  AST_UNLOCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(byte_done_i)); // R2
endmodule

// File: rtl/ulk_unlock_detector.sv
module ulk_unlock_detector #(
  parameter int unsigned                   BYTE_W      = ulk_pkg::DEF_BYTE_W,
  parameter int unsigned                   CODE_N      = ulk_pkg::DEF_CODE_N,
  parameter logic [CODE_N*BYTE_W-1:0]      CODE        = ulk_pkg::DEF_CODE,
  parameter int unsigned                   SYNC_STAGES = 2,
  parameter int unsigned                   RST_STAGES  = 2,
  localparam int unsigned                  CW          = $clog2(CODE_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              cmd_req_i,
  output logic              prog_mode_o,
  output logic [CW-1:0]     match_cnt_o,
  output logic              cmd_grant_o
);
  logic              rst_int_n;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              byte_clean;
  logic              unlocked;

  ulk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ulk_strobe_sampler #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .strobe_i     (strobe_i),
    .data_i       (data_i),
    .byte_done_o  (byte_done),
    .byte_val_o   (byte_val),
    .byte_clean_o (byte_clean)
  );

  ulk_seq_matcher #(.BYTE_W(BYTE_W), .CODE_N(CODE_N), .CODE(CODE)) u_match (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .byte_done_i  (byte_done),
    .byte_val_i   (byte_val),
    .byte_clean_i (byte_clean),
    .idx_o        (match_cnt_o),
    .unlocked_o   (unlocked)
  );

  assign prog_mode_o = unlocked;
  assign cmd_grant_o = cmd_req_i & unlocked;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_int_n |-> (!prog_mode_o && (match_cnt_o == '0))); // R1
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prog_mode_o && !cmd_req_i) |-> !cmd_grant_o); // R8
endmodule

// File: tb/tb_ulk_unlock_detector.sv
module tb_ulk_unlock_detector;
  logic       clk;
  logic       rst_n;
  logic       strobe;
  logic [7:0] data;
  logic       cmd_req;
  logic       mode;
  logic [3:0] cnt;
  logic       grant;

  int n_cmp;
  int n_bad;
  bit done;

  logic [7:0] code [8];

  ulk_unlock_detector dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (strobe),
    .data_i      (data),
    .cmd_req_i   (cmd_req),
    .prog_mode_o (mode),
    .match_cnt_o (cnt),
    .cmd_grant_o (grant)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    strobe = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // data set one cycle ahead, strobe high HI cycles, low 4 cycles
  task automatic pulse(input logic [7:0] b, input int hi);
    @(negedge clk);
    data = b;
    @(negedge clk);
    strobe = 1'b1;
    repeat (hi) @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // pulse whose data changes halfway through the high phase
  task automatic dirty_pulse(input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    data = b0;
    @(negedge clk);
    strobe = 1'b1;
    repeat (2) @(negedge clk);
    data = b1;
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    code[0] = 8'hA5; code[1] = 8'h5A; code[2] = 8'hA5; code[3] = 8'hF0;
    code[4] = 8'h0F; code[5] = 8'h00; code[6] = 8'hF1; code[7] = 8'h00;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; strobe = 1'b0; data = 8'h00; cmd_req = 1'b1;

    // R1: during and after reset
    repeat (2) @(negedge clk);
    check("R1 mode in reset", mode, 0);
    check("R1 count in reset", cnt, 0);
    check("R1 grant in reset", grant, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 mode after reset", mode, 0);
    check("R1 count after reset", cnt, 0);

    // R3 progression, R2 unlock timing, R8 grant gating
    for (int k = 0; k < 7; k++) begin
      pulse(code[k], 2);
      check("R3 count step", cnt, k + 1);
      check("R8 grant locked", grant, 0);
    end
    @(negedge clk);
    data = code[7];
    @(negedge clk);
    strobe = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 mode during last high", mode, 0);
    check("R2 count during last high", cnt, 7);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 mode after last fall", mode, 1);
    check("R3 count full", cnt, 8);
    check("R8 grant unlocked", grant, 1);
    cmd_req = 1'b0;
    @(negedge clk);
    check("R8 grant no request", grant, 0);
    cmd_req = 1'b1;

    // R6: sticky through arbitrary traffic
    for (int i = 0; i < 12; i++) begin
      pulse(8'(i * 37 + 5), 2);
      check("R6 mode sticky", mode, 1);
      check("R6 count sticky", cnt, 8);
    end
    pulse(8'hA5, 2);
    dirty_pulse(8'h11, 8'h22);
    check("R6 mode sticky after A5/dirty", mode, 1);
    check("R6 count sticky after A5/dirty", cnt, 8);

    // R7: reset leaves the mode
    do_reset();
    check("R7 mode after reset", mode, 0);
    check("R7 count after reset", cnt, 0);
    check("R8 grant after reset", grant, 0);

    // R5: unstable data during the high phase
    dirty_pulse(8'hA5, 8'h5A);
    check("R5 dirty first byte", cnt, 0);
    pulse(8'hA5, 2);
    pulse(8'h5A, 2);
    dirty_pulse(8'hA5, 8'hA4);
    check("R5 dirty third byte", cnt, 0);
    check("R5 mode stays", mode, 0);

    // R9: strobe already high across reset release
    @(negedge clk);
    rst_n = 1'b0; data = 8'hA5; strobe = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    strobe = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 held strobe discarded", cnt, 0);
    pulse(8'hA5, 2);
    check("R9 next pulse judged", cnt, 1);

    // R4 / R3 / R2: sweep every position against every byte value
    for (int k = 0; k < 8; k++) begin
      for (int v = 0; v < 256; v++) begin
        int exp_cnt;
        int exp_mode;
        do_reset();
        for (int j = 0; j < k; j++) pulse(code[j], 2);
        pulse(8'(v), 2);
        if (8'(v) == code[k]) exp_cnt = k + 1;
        else if (8'(v) == 8'hA5) exp_cnt = 1;
        else exp_cnt = 0;
        exp_mode = (8'(v) == code[k] && k == 7) ? 1 : 0;
        check("R4 sweep {mode,count}", {mode, cnt}, (exp_mode << 4) | exp_cnt);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule